// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This peripheral counts down a programmable number of ticks and escalates in two steps when software stops servicing it. A host reaches it over a small register bus: byte offsets, separate read and write strobes and 16-bit data. The host programs a start count, restarts the countdown, halts or runs the timer, and reads back the live count and the status flags. Each pulse on the tick input stands for one fixed timer period of 0.6 seconds; the prescaler that makes these pulses lies outside the block.

When the counter runs out the first time, the block raises a timeout flag and starts the countdown again. If software has not cleared that flag by the time the counter runs out again, the block records a second-timeout flag and a boot flag and emits a one-cycle reboot request. A no-reboot control bit blocks only that request; the flags are still recorded.

The escalation is held by a stage machine with three states. ST_QUIET means no timeout is pending. ST_WARNED means the timeout flag is set. ST_FIRE lasts one cycle and drives the reboot request. The transitions are as follows. An expiry moves ST_QUIET to ST_WARNED. An expiry in ST_WARNED moves to ST_FIRE, or stays in ST_WARNED while no-reboot is set. ST_FIRE returns to ST_WARNED. A write of 1 to the timeout flag moves ST_WARNED or ST_FIRE back to ST_QUIET, except in a cycle that also expires.

Top module: `wdt_two_stage`

## Requirements
- R1: After reset, reads give 0x0801 at offset 0x08 (halt bit 11 = 1, no-reboot bit 0 = 1), 0x0004 at offset 0x12 and at offset 0x00, and 0 at offsets 0x04 and 0x06. The reboot request is low.
- R2: Offset 0x12 holds the start count in bits 9:0. Bits 15:10 store whatever is written and read back unchanged.
- R3: A write to offset 0x12 whose bits 9:0 hold a value from 0 to 3 is dropped, and the whole register keeps its previous contents.
- R4: Any write to offset 0x00 loads the counter with the start count. A read of offset 0x00 returns the live count in bits 9:0 with bits 15:10 at zero.
- R5: While bit 11 at offset 0x08 is 1, ticks leave the count unchanged. While it is 0, each tick lowers the count by one.
- R6: A tick while the count is 0 is an expiry: the counter reloads the start count in that same cycle. If no timeout is pending, bit 3 at offset 0x04 is set. Writing 1 to that bit clears it.
- R7: An expiry while bit 3 at offset 0x04 is still set sets bit 1 (second timeout) and bit 2 (boot) at offset 0x06. Writing 1 to each bit clears it. If bit 3 was cleared before the expiry, only bit 3 is set again.
- R8: With bit 0 at offset 0x08 at 0, a second-stage expiry gives a reboot pulse exactly one clock long, in the cycle after the expiry.
- R9: With bit 0 at offset 0x08 at 1, a second-stage expiry gives no reboot pulse, but the flags at offset 0x06 are still set.
- R10: When a write to offset 0x00 and a tick fall in the same cycle, the counter takes the start count and does not decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse per timer period |
| bus_addr_i | input | ADDR_W | Byte offset of the access |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, valid in the cycle of the read strobe |
| reboot_o | output | 1 | One-cycle reboot request |

## Verification
The bench builds the block with its default parameters: a 10-bit counter, 8-bit offsets and a minimum start count of 4. It keeps the programmed start counts in the range 4 to 12, so both expiry stages complete within a few dozen ticks. That makes it possible to sweep every small start count, to check the count after each single tick, and to try all of the ignored values 0 to 3 together with the lowest accepted value.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
    localparam int DATA_W = 16;

    // register byte offsets
    localparam int OFS_COUNT = 'h00;
    localparam int OFS_STAT1 = 'h04;
    localparam int OFS_STAT2 = 'h06;
    localparam int OFS_CTRL  = 'h08;
    localparam int OFS_INIT  = 'h12;

    // field positions
    localparam int BIT_TIMEOUT = 3;
    localparam int BIT_SECOND  = 1;
    localparam int BIT_BOOT    = 2;
    localparam int BIT_HALT    = 11;
    localparam int BIT_NORB    = 0;

    typedef enum logic [1:0] {
        ST_QUIET  = 2'd0,
        ST_WARNED = 2'd1,
        ST_FIRE   = 2'd2
    } stage_e;
endpackage

// File: rtl/wdt_regs.sv
`timescale 1ns/1ps
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int CNT_W    = 10,
    parameter int ADDR_W   = 8,
    parameter int INIT_RST = 4,
    parameter int INIT_MIN = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              to_flag_i,
    input  logic              second_evt_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [CNT_W-1:0]  init_o,
    output logic              halt_o,
    output logic              norb_o,
    output logic              reload_o,
    output logic              clr_to_o
);
    logic [DATA_W-1:0] init_q;
    logic              halt_q;
    logic              norb_q;
    logic              second_q;
    logic              boot_q;

    logic wr_init, wr_ctrl, wr_stat2, init_ok;

    always_comb begin
        wr_init  = wr_i && (addr_i == ADDR_W'(OFS_INIT));
        wr_ctrl  = wr_i && (addr_i == ADDR_W'(OFS_CTRL));
        wr_stat2 = wr_i && (addr_i == ADDR_W'(OFS_STAT2));
        init_ok  = (wdata_i[CNT_W-1:0] >= CNT_W'(INIT_MIN));
        reload_o = wr_i && (addr_i == ADDR_W'(OFS_COUNT));
        clr_to_o = wr_i && (addr_i == ADDR_W'(OFS_STAT1)) && wdata_i[BIT_TIMEOUT];
    end

    // start count register: out-of-range counts are dropped whole
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            init_q <= DATA_W'(INIT_RST);
        end else if (wr_init && init_ok) begin
            init_q <= wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            halt_q <= 1'b1;
            norb_q <= 1'b1;
        end else if (wr_ctrl) begin
            halt_q <= wdata_i[BIT_HALT];
            norb_q <= wdata_i[BIT_NORB];
        end
    end

    // second-stage flags: a hardware set wins over a write-one clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            second_q <= 1'b0;
            boot_q   <= 1'b0;
        end else if (second_evt_i) begin
            second_q <= 1'b1;
            boot_q   <= 1'b1;
        end else if (wr_stat2) begin
            if (wdata_i[BIT_SECOND]) second_q <= 1'b0;
            if (wdata_i[BIT_BOOT])   boot_q   <= 1'b0;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (rd_i) begin
            case (addr_i)
                ADDR_W'(OFS_COUNT): rdata_o = DATA_W'(count_i);
                ADDR_W'(OFS_STAT1): rdata_o[BIT_TIMEOUT] = to_flag_i;
                ADDR_W'(OFS_STAT2): begin
                    rdata_o[BIT_SECOND] = second_q;
                    rdata_o[BIT_BOOT]   = boot_q;
                end
                ADDR_W'(OFS_CTRL): begin
                    rdata_o[BIT_HALT] = halt_q;
                    rdata_o[BIT_NORB] = norb_q;
                end
                ADDR_W'(OFS_INIT):  rdata_o = init_q;
                default:            rdata_o = '0;
            endcase
        end
    end

    assign init_o = init_q[CNT_W-1:0];
    assign halt_o = halt_q;
    assign norb_o = norb_q;
endmodule

// File: rtl/wdt_counter.sv
`timescale 1ns/1ps
module wdt_counter #(
    parameter int CNT_W    = 10,
    parameter int INIT_RST = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             halt_i,
    input  logic             reload_i,
    input  logic [CNT_W-1:0] init_i,
    output logic [CNT_W-1:0] count_o,
    output logic             expire_o
);
    logic [CNT_W-1:0] count_q;
    logic             step;

    always_comb begin
        step     = tick_i && !halt_i && !reload_i;
        expire_o = step && (count_q == '0);
    end

    // a host reload has priority over a tick in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            count_q <= CNT_W'(INIT_RST);
        end else if (reload_i) begin
            count_q <= init_i;
        end else if (step) begin
            if (count_q == '0) count_q <= init_i;
            else               count_q <= count_q - 1'b1;
        end
    end

    assign count_o = count_q;
endmodule

// File: rtl/wdt_stage_fsm.sv
`timescale 1ns/1ps
module wdt_stage_fsm
    import wdt_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic expire_i,
    input  logic clr_to_i,
    input  logic norb_i,
    output logic to_flag_o,
    output logic second_evt_o,
    output logic reboot_o
);
    stage_e state_q, state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_QUIET;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET: begin
                if (expire_i) state_d = ST_WARNED;
            end
            ST_WARNED: begin
                if (expire_i)      state_d = norb_i ? ST_WARNED : ST_FIRE;
                else if (clr_to_i) state_d = ST_QUIET;
            end
            ST_FIRE: begin
                if (expire_i)      state_d = norb_i ? ST_WARNED : ST_FIRE;
                else if (clr_to_i) state_d = ST_QUIET;
                else               state_d = ST_WARNED;
            end
            default: state_d = ST_QUIET;
        endcase
    end

    always_comb begin
        to_flag_o    = (state_q != ST_QUIET);
        second_evt_o = expire_i && (state_q != ST_QUIET);
        reboot_o     = (state_q == ST_FIRE);
    end
endmodule

// File: rtl/wdt_two_stage.sv
`timescale 1ns/1ps
module wdt_two_stage
    import wdt_pkg::*;
#(
    parameter int CNT_W    = 10,
    parameter int ADDR_W   = 8,
    parameter int INIT_RST = 4,
    parameter int INIT_MIN = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [15:0]       bus_wdata_i,
    output logic [15:0]       bus_rdata_o,
    output logic              reboot_o
);
    logic [CNT_W-1:0] count_w;
    logic [CNT_W-1:0] init_w;
    logic             halt_w, norb_w, reload_w, clr_to_w;
    logic             expire_w, to_flag_w, second_w;

    wdt_regs #(
        .CNT_W(CNT_W), .ADDR_W(ADDR_W), .INIT_RST(INIT_RST), .INIT_MIN(INIT_MIN)
    ) regs_i (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .addr_i(bus_addr_i), .wr_i(bus_wr_i), .rd_i(bus_rd_i), .wdata_i(bus_wdata_i),
        .count_i(count_w), .to_flag_i(to_flag_w), .second_evt_i(second_w),
        .rdata_o(bus_rdata_o), .init_o(init_w), .halt_o(halt_w), .norb_o(norb_w),
        .reload_o(reload_w), .clr_to_o(clr_to_w)
    );

    wdt_counter #(.CNT_W(CNT_W), .INIT_RST(INIT_RST)) cnt_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .halt_i(halt_w),
        .reload_i(reload_w), .init_i(init_w), .count_o(count_w), .expire_o(expire_w)
    );

    wdt_stage_fsm fsm_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .expire_i(expire_w), .clr_to_i(clr_to_w),
        .norb_i(norb_w), .to_flag_o(to_flag_w), .second_evt_o(second_w),
        .reboot_o(reboot_o)
    );
endmodule

// File: rtl/wdt_two_stage_chk.sv
`timescale 1ns/1ps
module wdt_two_stage_chk #(
    parameter int CNT_W    = 10,
    parameter int INIT_MIN = 4
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             tick_i,
    input logic             reboot_o,
    input logic [CNT_W-1:0] count_w,
    input logic [CNT_W-1:0] init_w,
    input logic             halt_w,
    input logic             norb_w,
    input logic             reload_w,
    input logic             to_flag_w
);
    // R3
    init_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        init_w >= CNT_W'(INIT_MIN));

    // R5
    halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (halt_w && !reload_w) |=> $stable(count_w));

    // R5
    run_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !halt_w && !reload_w && count_w != '0)
        |=> count_w == CNT_W'($past(count_w) - 1'b1));

    // R6
    expiry_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !halt_w && !reload_w && count_w == '0)
        |=> (count_w == $past(init_w)) && to_flag_w);

    // R8
    reboot_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reboot_o |=> !reboot_o);

    // R9
    norb_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        norb_w |=> !reboot_o);

    // R10
    reload_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reload_w |=> count_w == $past(init_w));
endmodule

bind wdt_two_stage wdt_two_stage_chk #(.CNT_W(CNT_W), .INIT_MIN(INIT_MIN)) chk_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .reboot_o(reboot_o),
    .count_w(count_w), .init_w(init_w), .halt_w(halt_w), .norb_w(norb_w),
    .reload_w(reload_w), .to_flag_w(to_flag_w)
);

// File: tb/wdt_two_stage_tb_top.sv
`timescale 1ns/1ps
module wdt_two_stage_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        reboot;

    int checks = 0;
    int fails = 0;
    int rb_cnt = 0;
    logic rb_prev = 1'b0;
    logic [15:0] v;

    always #2.5 clk = ~clk;

    wdt_two_stage dut_i (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .bus_addr_i(addr),
        .bus_wr_i(wr), .bus_rd_i(rd), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .reboot_o(reboot)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk); wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk); rd = 1'b1; addr = a;
        #1 d = rdata;
        rd = 1'b0;
    endtask

    task automatic do_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // reboot pulse monitor: count pulses and flag any pulse longer than one cycle (R8)
    always @(negedge clk) begin
        if (rst_n) begin
            if (reboot && !rb_prev) rb_cnt++;
            if (reboot && rb_prev) begin
                checks++; fails++;
                $display("FAIL R8 actual=wide expected=single-cycle");
            end
            rb_prev = reboot;
        end
    end

    initial begin
        #(5.0 * 100000);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        int rb0;
        repeat (3) @(negedge clk);
        #1 chk("R1 reboot", {15'd0, reboot}, 16'd0);
        rst_n = 1'b1;

        // R1 reset values
        bus_rd(8'h08, v); chk("R1 ctrl", v, 16'h0801);
        bus_rd(8'h12, v); chk("R1 init", v, 16'h0004);
        bus_rd(8'h00, v); chk("R1 count", v, 16'h0004);
        bus_rd(8'h04, v); chk("R1 stat1", v, 16'h0000);
        bus_rd(8'h06, v); chk("R1 stat2", v, 16'h0000);

        // R3: every value below 4 dropped, even with upper bits set
        for (int i = 0; i < 4; i++) begin
            bus_wr(8'h12, 16'hA800 | 16'(i));
            bus_rd(8'h12, v); chk("R3 ignored", v, 16'h0004);
        end
        // R2: upper bits stored alongside the count
        bus_wr(8'h12, 16'hFC07);
        bus_rd(8'h12, v); chk("R2 upper", v, 16'hFC07);
        bus_wr(8'h12, 16'h0404);
        bus_rd(8'h12, v); chk("R2 min", v, 16'h0404);

        // R4: reload and readback with upper bits zero
        bus_wr(8'h00, 16'hFFFF);
        bus_rd(8'h00, v); chk("R4 reload", v, 16'h0004);

        // R5: halted ticks hold
        bus_wr(8'h12, 16'd9); bus_wr(8'h00, 16'd0);
        repeat (3) do_tick();
        bus_rd(8'h00, v); chk("R5 halt", v, 16'd9);

        // run, no-reboot off
        bus_wr(8'h08, 16'h0000);
        bus_rd(8'h08, v); chk("R5 ctrl", v, 16'h0000);

        // R5/R6 sweep of start counts, first stage only
        for (int n = 4; n <= 12; n++) begin
            bus_wr(8'h12, 16'(n)); bus_wr(8'h00, 16'd0);
            for (int k = 1; k <= n; k++) begin
                do_tick();
                bus_rd(8'h00, v); chk("R5 step", v, 16'(n - k));
            end
            bus_rd(8'h04, v); chk("R6 pre", v, 16'h0000);
            do_tick();
            bus_rd(8'h00, v); chk("R6 reload", v, 16'(n));
            bus_rd(8'h04, v); chk("R6 flag", v, 16'h0008);
            bus_wr(8'h04, 16'h0008);
            bus_rd(8'h04, v); chk("R6 clear", v, 16'h0000);
        end

        // R7: flag cleared between expiries means no second stage
        bus_wr(8'h12, 16'd4); bus_wr(8'h00, 16'd0);
        rb0 = rb_cnt;
        repeat (5) do_tick();
        bus_wr(8'h04, 16'h0008);
        repeat (5) do_tick();
        bus_rd(8'h04, v); chk("R7 reset", v, 16'h0008);
        bus_rd(8'h06, v); chk("R7 none", v, 16'h0000);
        chk("R8 none", 16'(rb_cnt - rb0), 16'd0);
        bus_wr(8'h04, 16'h0008);

        // R7/R8 second stage sweep
        for (int n = 4; n <= 7; n++) begin
            bus_wr(8'h12, 16'(n)); bus_wr(8'h00, 16'd0);
            rb0 = rb_cnt;
            repeat (n + 1) do_tick();
            chk("R8 early", 16'(rb_cnt - rb0), 16'd0);
            repeat (n + 1) do_tick();
            #1 chk("R8 pulse", 16'(rb_cnt - rb0), 16'd1);
            bus_rd(8'h06, v); chk("R7 set", v, 16'h0006);
            bus_rd(8'h04, v); chk("R7 flag", v, 16'h0008);
            bus_wr(8'h06, 16'h0002);
            bus_rd(8'h06, v); chk("R7 clr second", v, 16'h0004);
            bus_wr(8'h06, 16'h0004);
            bus_rd(8'h06, v); chk("R7 clr boot", v, 16'h0000);
            bus_wr(8'h04, 16'h0008);
        end

        // R9: no-reboot bit set
        bus_wr(8'h08, 16'h0001);
        bus_wr(8'h12, 16'd5); bus_wr(8'h00, 16'd0);
        rb0 = rb_cnt;
        repeat (12) do_tick();
        repeat (2) @(negedge clk);
        chk("R9 blocked", 16'(rb_cnt - rb0), 16'd0);
        bus_rd(8'h06, v); chk("R9 flags", v, 16'h0006);
        bus_wr(8'h06, 16'h0006); bus_wr(8'h04, 16'h0008);

        // R10: reload and tick together
        bus_wr(8'h12, 16'd8); bus_wr(8'h00, 16'd0);
        repeat (3) do_tick();
        bus_rd(8'h00, v); chk("R10 pre", v, 16'd5);
        @(negedge clk); tick = 1'b1; wr = 1'b1; addr = 8'h00; wdata = 16'd0;
        @(negedge clk); tick = 1'b0; wr = 1'b0;
        bus_rd(8'h00, v); chk("R10 reload wins", v, 16'd8);

        finish_run();
    end
endmodule